// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block lets a synchronous host change the contents of an asynchronous parallel NOR flash with a single request. The host offers a request with an operation code, a target address and a data byte through a valid/ready handshake. The sequencer then writes the unlock command cycles to the flash bus. Each write is a pulse on the write strobe with minimum widths counted in clock cycles. The last cycle is the command or data that starts the internal operation.

The block does not wait a fixed worst-case time after the last write. It reads the target location repeatedly and watches bit 7 of the returned byte. While the operation runs, bit 7 is the complement of the final value. Once the operation ends, bit 7 holds the true value. When bit 7 matches, the block raises `done` for one cycle. If the operation runs past a time limit, the sequencer holds the flash reset line low for a set time, then reports `done` together with `err`.

Every bus timing is a parameter in system clock cycles, so the same code can be used at any clock rate. The read side of the bus is reduced to the one bit that polling needs. The write side is an 8-bit output with a separate enable, to be joined to a pad-level tristate outside the block.

Top module: `flash_seq`

## Requirements
- R1: After reset, the outputs are idle: `req_ready`=1, `done`=0, `err`=0, `f_cs_n`=`f_we_n`=`f_oe_n`=`f_rst_n`=1 and `f_dq_oe`=0.
- R2: A request with `req_op`=2'b00 (program) issues four write pulses, in this order as (data@address): AAh@5555h, 55h@2AAAh, A0h@5555h, `req_data`@`req_addr`.
- R3: A request with `req_op`=2'b01 (sector erase) issues six write pulses: AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 30h@`req_addr`. With `req_op[1]`=1 (chip erase) the same first five are followed by 10h@5555h.
- R4: Each write pulse holds `f_we_n` low for at least WE_LOW_CYC cycles, and `f_we_n` stays high for at least WE_HIGH_CYC cycles between pulses of one request. `f_addr` and `f_dq_o` do not change while `f_we_n` is low.
- R5: `f_dq_oe` is high only while `f_we_n` is low and `f_oe_n` is high.
- R6: `f_we_n` and `f_oe_n` are never low together. After the final write, `f_oe_n` stays high for at least OE_HOLD_CYC cycles before the first poll read.
- R7: A poll read drives `f_addr`=`req_addr` and holds `f_oe_n` low for RD_CYC cycles, then high for RD_GAP_CYC cycles. The request is complete when `f_dq7_i`, sampled in the last low cycle, equals `req_data[7]` (program) or 1 (erase). Completion raises `done` with `err`=0, exactly WL·n + WH·(n−1) + OE_HOLD_CYC + k·(RD_CYC+RD_GAP_CYC) cycles after the accepting edge, where n is the number of writes and k the number of reads.
- R8: If a poll read does not match and the poll time has reached the limit for the operation (PROG_TO_CYC, SECT_TO_CYC or CHIP_TO_CYC), `f_rst_n` goes low for exactly RST_CYC cycles with `f_cs_n` high, and then `done` and `err` rise together.
- R9: A request is taken only on a cycle with `req_valid`=1 and `req_ready`=1. `req_ready` is high only when the bus is idle. A request held valid while the block is busy has no effect.
- R10: `done` and `err` are high for one cycle at a time, and `err` is never high without `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host offers a request |
| req_ready | output | 1 | Block is idle and takes a request |
| req_op | input | 2 | 00 program, 01 sector erase, 1x chip erase |
| req_addr | input | ADDR_W | Target byte or sector address |
| req_data | input | 8 | Byte to program |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Qualifies `done`: the operation timed out |
| f_cs_n | output | 1 | Flash chip select, active low |
| f_we_n | output | 1 | Flash write strobe, active low |
| f_oe_n | output | 1 | Flash output enable, active low |
| f_rst_n | output | 1 | Flash reset, active low |
| f_addr | output | ADDR_W | Flash address |
| f_dq_o | output | 8 | Byte driven toward the flash |
| f_dq_oe | output | 1 | Enable for the data driver |
| f_dq7_i | input | 1 | Bit 7 read from the flash data bus |

## Verification
Every bus output is registered from the next state, so a phase entered at an edge appears at that edge. The completion pulse of a request is therefore due at a cycle count fixed by the sum of the phase lengths in R7. The timeout pulse is due after the writes, the eight failed polls and the RST_CYC reset phase. The bench counts falling clock edges from the accepting edge and compares that count with the sum computed from its own parameters. It samples strobes, address and data on falling edges, half a cycle away from the edge that moves them. Pulse widths, hold gaps and stability are measured as run lengths of those samples.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  // operation codes on req_op
  localparam logic [1:0] OP_PROG = 2'b00;
  localparam logic [1:0] OP_SECT = 2'b01;

  // command bytes and unlock addresses
  localparam logic [15:0] UNLK_HI  = 16'h5555;
  localparam logic [15:0] UNLK_LO  = 16'h2AAA;
  localparam logic [7:0]  KEY_1    = 8'hAA;
  localparam logic [7:0]  KEY_2    = 8'h55;
  localparam logic [7:0]  CMD_PROG = 8'hA0;
  localparam logic [7:0]  CMD_ERS  = 8'h80;
  localparam logic [7:0]  CMD_SECT = 8'h30;
  localparam logic [7:0]  CMD_CHIP = 8'h10;

  localparam int STEP_W = 3;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WLOW,
    S_WHIGH,
    S_OEHOLD,
    S_RDLO,
    S_RDGAP,
    S_RST
  } seq_state_e;

endpackage

// File: rtl/flash_seq_tmr.sv
module flash_seq_tmr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/flash_seq_wdog.sv
module flash_seq_wdog #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] limit,
  output logic         expired
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (en && (cnt_q != '1)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired = (cnt_q >= limit);

endmodule

// File: rtl/flash_seq_cmd.sv
module flash_seq_cmd
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W = 21
) (
  input  logic [1:0]        op,
  input  logic [STEP_W-1:0] step,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic [7:0]        tgt_data,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [7:0]        cmd_data,
  output logic [STEP_W-1:0] last_step
);

  localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(UNLK_HI);
  localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(UNLK_LO);

  logic is_prog;
  logic is_sect;

  assign is_prog   = (op == OP_PROG);
  assign is_sect   = (op == OP_SECT);
  assign last_step = is_prog ? STEP_W'(3) : STEP_W'(5);

  always_comb begin
    cmd_addr = A_HI;
    cmd_data = KEY_1;
    case (step)
      3'd0: begin
        cmd_addr = A_HI;
        cmd_data = KEY_1;
      end
      3'd1, 3'd4: begin
        cmd_addr = A_LO;
        cmd_data = KEY_2;
      end
      3'd2: begin
        cmd_addr = A_HI;
        cmd_data = is_prog ? CMD_PROG : CMD_ERS;
      end
      3'd3: begin
        cmd_addr = is_prog ? tgt_addr : A_HI;
        cmd_data = is_prog ? tgt_data : KEY_1;
      end
      3'd5: begin
        cmd_addr = is_sect ? tgt_addr : A_HI;
        cmd_data = is_sect ? CMD_SECT : CMD_CHIP;
      end
      default: begin
        cmd_addr = A_HI;
        cmd_data = KEY_1;
      end
    endcase
  end

endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_seq_pkg::*;
#(
  parameter int                ADDR_W      = 21,
  parameter int unsigned       WE_LOW_CYC  = 10,
  parameter int unsigned       WE_HIGH_CYC = 5,
  parameter int unsigned       OE_HOLD_CYC = 2,
  parameter int unsigned       RD_CYC      = 30,
  parameter int unsigned       RD_GAP_CYC  = 8,
  parameter int unsigned       RST_CYC     = 110,
  parameter longint unsigned   PROG_TO_CYC = 64'd60_000,
  parameter longint unsigned   SECT_TO_CYC = 64'd3_000_000_000,
  parameter longint unsigned   CHIP_TO_CYC = 64'd51_200_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_data,
  output logic              done,
  output logic              err,
  output logic              f_cs_n,
  output logic              f_we_n,
  output logic              f_oe_n,
  output logic              f_rst_n,
  output logic [ADDR_W-1:0] f_addr,
  output logic [7:0]        f_dq_o,
  output logic              f_dq_oe,
  input  logic              f_dq7_i
);

  localparam int unsigned PH_M1  = (WE_LOW_CYC > WE_HIGH_CYC) ? WE_LOW_CYC : WE_HIGH_CYC;
  localparam int unsigned PH_M2  = (RD_CYC > RD_GAP_CYC) ? RD_CYC : RD_GAP_CYC;
  localparam int unsigned PH_M3  = (RST_CYC > OE_HOLD_CYC) ? RST_CYC : OE_HOLD_CYC;
  localparam int unsigned PH_M12 = (PH_M1 > PH_M2) ? PH_M1 : PH_M2;
  localparam int unsigned PH_MAX = (PH_M12 > PH_M3) ? PH_M12 : PH_M3;
  localparam int          PH_W   = $clog2(PH_MAX + 1);

  localparam longint unsigned TO_M1  = (PROG_TO_CYC > SECT_TO_CYC) ? PROG_TO_CYC : SECT_TO_CYC;
  localparam longint unsigned TO_MAX = (TO_M1 > CHIP_TO_CYC) ? TO_M1 : CHIP_TO_CYC;
  localparam int              TO_W   = $clog2(TO_MAX + 64'd1) + 1;

  seq_state_e        st_q, st_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [1:0]        op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;
  logic              bit7_q;

  logic              accept;
  logic [1:0]        op_m;
  logic [ADDR_W-1:0] addr_m;
  logic [7:0]        data_m;
  logic [ADDR_W-1:0] cmd_addr;
  logic [7:0]        cmd_data;
  logic [STEP_W-1:0] last_step;

  logic              ph_ld;
  logic [PH_W-1:0]   ph_val;
  logic              ph_zero;

  logic              wd_en;
  logic [TO_W-1:0]   wd_limit;
  logic              wd_exp;

  logic              exp7;
  logic              match;
  logic              fin_ok;
  logic              fin_bad;

  // ---------------- handshake and request capture ----------------
  assign req_ready = (st_q == S_IDLE);
  assign accept    = req_valid && req_ready;

  // while idle the command table sees the incoming request, so the first
  // write cycle can leave on the accepting edge
  assign op_m   = accept ? req_op   : op_q;
  assign addr_m = accept ? req_addr : addr_q;
  assign data_m = accept ? req_data : data_q;

  flash_seq_cmd #(
    .ADDR_W (ADDR_W)
  ) u_cmd (
    .op        (op_m),
    .step      (step_d),
    .tgt_addr  (addr_m),
    .tgt_data  (data_m),
    .cmd_addr  (cmd_addr),
    .cmd_data  (cmd_data),
    .last_step (last_step)
  );

  // ---------------- poll result ----------------
  assign exp7  = (op_q == OP_PROG) ? data_q[7] : 1'b1;
  assign match = (bit7_q == exp7);

  // ---------------- next-state logic ----------------
  always_comb begin
    st_d   = st_q;
    step_d = step_q;
    case (st_q)
      S_IDLE: begin
        if (accept) begin
          st_d   = S_WLOW;
          step_d = '0;
        end
      end
      S_WLOW: begin
        if (ph_zero) begin
          st_d = (step_q == last_step) ? S_OEHOLD : S_WHIGH;
        end
      end
      S_WHIGH: begin
        if (ph_zero) begin
          st_d   = S_WLOW;
          step_d = step_q + 1'b1;
        end
      end
      S_OEHOLD: begin
        if (ph_zero) st_d = S_RDLO;
      end
      S_RDLO: begin
        if (ph_zero) st_d = S_RDGAP;
      end
      S_RDGAP: begin
        if (ph_zero) begin
          if (match)       st_d = S_IDLE;
          else if (wd_exp) st_d = S_RST;
          else             st_d = S_RDLO;
        end
      end
      S_RST: begin
        if (ph_zero) st_d = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  // ---------------- phase timer ----------------
  assign ph_ld = (st_d != st_q);

  always_comb begin
    case (st_d)
      S_WLOW:   ph_val = PH_W'(WE_LOW_CYC - 1);
      S_WHIGH:  ph_val = PH_W'(WE_HIGH_CYC - 1);
      S_OEHOLD: ph_val = PH_W'(OE_HOLD_CYC - 1);
      S_RDLO:   ph_val = PH_W'(RD_CYC - 1);
      S_RDGAP:  ph_val = PH_W'(RD_GAP_CYC - 1);
      S_RST:    ph_val = PH_W'(RST_CYC - 1);
      default:  ph_val = '0;
    endcase
  end

  flash_seq_tmr #(
    .W (PH_W)
  ) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (ph_ld),
    .load_val (ph_val),
    .zero     (ph_zero)
  );

  // ---------------- operation timeout ----------------
  assign wd_en = (st_q == S_OEHOLD) || (st_q == S_RDLO) || (st_q == S_RDGAP);

  always_comb begin
    if (op_q == OP_PROG)      wd_limit = TO_W'(PROG_TO_CYC);
    else if (op_q == OP_SECT) wd_limit = TO_W'(SECT_TO_CYC);
    else                      wd_limit = TO_W'(CHIP_TO_CYC);
  end

  flash_seq_wdog #(
    .W (TO_W)
  ) u_wdog (
    .clk     (clk),
    .rst     (rst),
    .clr     (accept),
    .en      (wd_en),
    .limit   (wd_limit),
    .expired (wd_exp)
  );

  assign fin_ok  = (st_q == S_RDGAP) && ph_zero && match;
  assign fin_bad = (st_q == S_RST) && ph_zero;

  // ---------------- state and registered bus outputs ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= S_IDLE;
      step_q  <= '0;
      op_q    <= OP_PROG;
      addr_q  <= '0;
      data_q  <= '0;
      bit7_q  <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
      f_cs_n  <= 1'b1;
      f_we_n  <= 1'b1;
      f_oe_n  <= 1'b1;
      f_rst_n <= 1'b1;
      f_addr  <= '0;
      f_dq_o  <= '0;
      f_dq_oe <= 1'b0;
    end else begin
      st_q   <= st_d;
      step_q <= step_d;
      if (accept) begin
        op_q   <= req_op;
        addr_q <= req_addr;
        data_q <= req_data;
      end
      if ((st_q == S_RDLO) && ph_zero) begin
        bit7_q <= f_dq7_i;
      end
      done    <= fin_ok || fin_bad;
      err     <= fin_bad;
      f_cs_n  <= (st_d == S_IDLE) || (st_d == S_RST);
      f_we_n  <= (st_d != S_WLOW);
      f_dq_oe <= (st_d == S_WLOW);
      f_oe_n  <= (st_d != S_RDLO);
      f_rst_n <= (st_d != S_RST);
      if (st_d == S_WLOW) begin
        f_addr <= cmd_addr;
        f_dq_o <= cmd_data;
      end else if ((st_d == S_OEHOLD) || (st_d == S_RDLO) || (st_d == S_RDGAP)) begin
        f_addr <= addr_q;
      end
    end
  end

endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk #(
  parameter int ADDR_W = 21
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              done,
  input logic              err,
  input logic              f_cs_n,
  input logic              f_we_n,
  input logic              f_oe_n,
  input logic              f_rst_n,
  input logic [ADDR_W-1:0] f_addr,
  input logic [7:0]        f_dq_o,
  input logic              f_dq_oe
);

  // R4: address and data hold still through a write pulse
  p_wr_stable_r4: assert property (@(posedge clk) disable iff (rst)
    (!f_we_n && !$past(f_we_n)) |-> ($stable(f_addr) && $stable(f_dq_o)));

  // R5: data driver only inside a write pulse with OE released
  p_drv_window_r5: assert property (@(posedge clk) disable iff (rst)
    f_dq_oe |-> (!f_we_n && f_oe_n));

  // R6: write and read strobes never overlap
  p_no_overlap_r6: assert property (@(posedge clk) disable iff (rst)
    !f_we_n |-> f_oe_n);

  // R8: chip deselected while flash reset is low
  p_rst_desel_r8: assert property (@(posedge clk) disable iff (rst)
    !f_rst_n |-> f_cs_n);

  // R9: ready only with an idle bus
  p_ready_idle_r9: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (f_cs_n && f_we_n && f_oe_n && f_rst_n));

  // R10: one-cycle completion pulse
  p_done_once_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10: error flag only together with done
  p_err_done_r10: assert property (@(posedge clk) disable iff (rst)
    err |-> done);

endmodule

bind flash_seq flash_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_ready (req_ready),
  .done      (done),
  .err       (err),
  .f_cs_n    (f_cs_n),
  .f_we_n    (f_we_n),
  .f_oe_n    (f_oe_n),
  .f_rst_n   (f_rst_n),
  .f_addr    (f_addr),
  .f_dq_o    (f_dq_o),
  .f_dq_oe   (f_dq_oe)
);

// File: tb/flash_seq_tb.sv
`timescale 1ns/1ps
module flash_seq_tb;

  localparam int AW  = 21;
  localparam int WL  = 10;
  localparam int WH  = 5;
  localparam int OEH = 2;
  localparam int RD  = 30;
  localparam int GAP = 8;
  localparam int RSC = 110;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_op = 2'b00;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]    req_data = '0;
  logic          done, err;
  logic          f_cs_n, f_we_n, f_oe_n, f_rst_n, f_dq_oe;
  logic [AW-1:0] f_addr;
  logic [7:0]    f_dq_o;
  logic          f_dq7_i;

  always #2.5 clk = ~clk;

  flash_seq #(
    .ADDR_W(AW), .WE_LOW_CYC(WL), .WE_HIGH_CYC(WH), .OE_HOLD_CYC(OEH),
    .RD_CYC(RD), .RD_GAP_CYC(GAP), .RST_CYC(RSC),
    .PROG_TO_CYC(64'd300), .SECT_TO_CYC(64'd600), .CHIP_TO_CYC(64'd900)
  ) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
    .done(done), .err(err), .f_cs_n(f_cs_n), .f_we_n(f_we_n),
    .f_oe_n(f_oe_n), .f_rst_n(f_rst_n), .f_addr(f_addr), .f_dq_o(f_dq_o),
    .f_dq_oe(f_dq_oe), .f_dq7_i(f_dq7_i)
  );

  int n_chk = 0;
  int n_fail = 0;

  // ---------------- flash model ----------------
  bit final7 = 1'b1;
  int busy_reads = 0;
  int reads = 0;
  assign f_dq7_i = (!f_oe_n && !f_cs_n) ? ((reads > busy_reads) ? final7 : ~final7) : 1'b0;

  // ---------------- bus monitor ----------------
  logic [AW-1:0] log_a [0:15];
  logic [7:0]    log_d [0:15];
  int log_n = 0;
  logic [AW-1:0] cur_a, poll_a;
  logic [7:0]    cur_d;
  int we_lo_run = 0, we_hi_run = 0, since_we = 0, rst_run = 0;
  int min_lo = 9999, min_hi = 9999, min_oeh = 9999, rst_len = 0;
  int stab_bad = 0, drv_bad = 0, rdy_bad = 0, poll_bad = 0;
  bit have_pulse = 0;
  logic prev_we = 1'b1, prev_oe = 1'b1, prev_rst = 1'b1;

  always @(negedge clk) begin
    if (!rst) begin
      if (f_dq_oe && (f_we_n || !f_oe_n)) drv_bad++;
      if (req_ready && !f_cs_n) rdy_bad++;
      if (!f_oe_n && prev_oe) begin
        reads++;
        if (since_we < min_oeh) min_oeh = since_we;
        if (f_addr != poll_a) poll_bad++;
      end
      if (!f_we_n) begin
        if (prev_we) begin
          we_lo_run = 0;
          if (have_pulse && we_hi_run < min_hi) min_hi = we_hi_run;
        end else if (f_addr != cur_a || f_dq_o != cur_d) begin
          stab_bad++;
        end
        we_lo_run++;
        cur_a = f_addr;
        cur_d = f_dq_o;
      end else begin
        if (!prev_we) begin
          if (log_n < 16) begin
            log_a[log_n] = cur_a;
            log_d[log_n] = cur_d;
          end
          log_n++;
          if (we_lo_run < min_lo) min_lo = we_lo_run;
          we_hi_run = 0;
          since_we = 0;
          have_pulse = 1'b1;
        end
        we_hi_run++;
        since_we++;
      end
      if (!f_rst_n) rst_run++;
      else if (!prev_rst) rst_len = rst_run;
      if (f_rst_n && prev_rst) rst_run = 0;
      prev_we = f_we_n;
      prev_oe = f_oe_n;
      prev_rst = f_rst_n;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic clear_stats(input logic [AW-1:0] a);
    log_n = 0; reads = 0; min_lo = 9999; min_hi = 9999; min_oeh = 9999;
    rst_len = 0; stab_bad = 0; drv_bad = 0; rdy_bad = 0; poll_bad = 0;
    have_pulse = 1'b0; poll_a = a;
  endtask

  // drives one request; keeps req_valid up with other fields for 'hold' cycles
  task automatic issue(input logic [1:0] op, input logic [AW-1:0] a, input logic [7:0] d,
                       input bit f7, input int busy, input int hold,
                       output int cyc, output bit got_err);
    clear_stats(a);
    final7 = f7;
    busy_reads = busy;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
    @(posedge clk);
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
      if (cyc > hold) req_valid = 1'b0;
      else begin req_op = 2'b10; req_addr = 21'h0F0F0F; req_data = 8'h00; end
    end while (!done && cyc < 20000);
    req_valid = 1'b0;
    got_err = err;
    @(negedge clk);
    chk(done == 1'b0, "R10 done width", done, 0);
  endtask

  task automatic chk_timing(input string tag, input int n);
    chk(min_lo >= WL, {tag, " R4 we low"}, min_lo, WL);
    chk(n < 2 || min_hi >= WH, {tag, " R4 we high"}, min_hi, WH);
    chk(stab_bad == 0, {tag, " R4 stable"}, stab_bad, 0);
    chk(drv_bad == 0, {tag, " R5 driver"}, drv_bad, 0);
    chk(min_oeh >= OEH, {tag, " R6 oe hold"}, min_oeh, OEH);
    chk(poll_bad == 0, {tag, " R7 poll addr"}, poll_bad, 0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
    chk(done == 1'b0 && err == 1'b0, "R1 done/err", {done, err}, 0);
    chk({f_cs_n, f_we_n, f_oe_n, f_rst_n} == 4'hF, "R1 strobes", {f_cs_n, f_we_n, f_oe_n, f_rst_n}, 4'hF);
    chk(f_dq_oe == 1'b0, "R1 dq_oe", f_dq_oe, 0);
  endtask

  task automatic t_prog_hi();
    int c; bit e;
    issue(2'b00, 21'h1ABCDE, 8'hA5, 1'b1, 2, 0, c, e);
    chk(log_n == 4, "R2 write count", log_n, 4);
    chk(log_a[0] == 21'h5555 && log_d[0] == 8'hAA, "R2 w0", {log_a[0], log_d[0]}, {21'h5555, 8'hAA});
    chk(log_a[1] == 21'h2AAA && log_d[1] == 8'h55, "R2 w1", {log_a[1], log_d[1]}, {21'h2AAA, 8'h55});
    chk(log_a[2] == 21'h5555 && log_d[2] == 8'hA0, "R2 w2", {log_a[2], log_d[2]}, {21'h5555, 8'hA0});
    chk(log_a[3] == 21'h1ABCDE && log_d[3] == 8'hA5, "R2 w3", {log_a[3], log_d[3]}, {21'h1ABCDE, 8'hA5});
    chk(reads == 3, "R7 read count", reads, 3);
    chk(c == 4*WL + 3*WH + OEH + 3*(RD+GAP) + 1, "R7 done cycle", c, 4*WL + 3*WH + OEH + 3*(RD+GAP) + 1);
    chk(e == 1'b0, "R7 err", e, 0);
    chk_timing("prog", 4);
  endtask

  task automatic t_prog_lo();
    int c; bit e;
    issue(2'b00, 21'h000123, 8'h35, 1'b0, 0, 0, c, e);
    chk(log_d[3] == 8'h35, "R2 data", log_d[3], 8'h35);
    chk(reads == 1, "R7 bit7=0 match", reads, 1);
    chk(c == 4*WL + 3*WH + OEH + (RD+GAP) + 1, "R7 done cycle lo", c, 4*WL + 3*WH + OEH + (RD+GAP) + 1);
    chk(e == 1'b0, "R7 err lo", e, 0);
  endtask

  task automatic t_sector();
    int c; bit e;
    logic [AW-1:0] ea [0:5];
    logic [7:0]    ed [0:5];
    ea = '{21'h5555, 21'h2AAA, 21'h5555, 21'h5555, 21'h2AAA, 21'h0A0000};
    ed = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h30};
    issue(2'b01, 21'h0A0000, 8'h00, 1'b1, 3, 0, c, e);
    chk(log_n == 6, "R3 sector count", log_n, 6);
    for (int i = 0; i < 6; i++)
      chk(log_a[i] == ea[i] && log_d[i] == ed[i], "R3 sector write", {log_a[i], log_d[i]}, {ea[i], ed[i]});
    chk(c == 6*WL + 5*WH + OEH + 4*(RD+GAP) + 1, "R7 erase done cycle", c, 6*WL + 5*WH + OEH + 4*(RD+GAP) + 1);
    chk(e == 1'b0, "R7 erase err", e, 0);
    chk_timing("sector", 6);
  endtask

  task automatic t_chip();
    int c; bit e;
    issue(2'b11, 21'h123456, 8'h00, 1'b1, 1, 0, c, e);
    chk(log_n == 6, "R3 chip count", log_n, 6);
    chk(log_a[2] == 21'h5555 && log_d[2] == 8'h80, "R3 chip w2", {log_a[2], log_d[2]}, {21'h5555, 8'h80});
    chk(log_a[5] == 21'h5555 && log_d[5] == 8'h10, "R3 chip last", {log_a[5], log_d[5]}, {21'h5555, 8'h10});
    chk(c == 6*WL + 5*WH + OEH + 2*(RD+GAP) + 1, "R7 chip done cycle", c, 6*WL + 5*WH + OEH + 2*(RD+GAP) + 1);
  endtask

  task automatic t_busy_ignore();
    int c; bit e;
    issue(2'b00, 21'h0000F0, 8'h5A, 1'b0, 1, 25, c, e);
    chk(log_n == 4, "R9 writes while busy", log_n, 4);
    chk(log_a[3] == 21'h0000F0 && log_d[3] == 8'h5A, "R9 target kept", {log_a[3], log_d[3]}, {21'h0000F0, 8'h5A});
    chk(rdy_bad == 0, "R9 ready busy", rdy_bad, 0);
    repeat (20) @(negedge clk);
    chk(log_n == 4 && req_ready == 1'b1, "R9 idle after", log_n, 4);
  endtask

  task automatic t_timeout();
    int c; bit e;
    issue(2'b00, 21'h000777, 8'h80, 1'b1, 1000, 0, c, e);
    chk(e == 1'b1, "R8 err", e, 1);
    chk(rst_len == RSC, "R8 reset width", rst_len, RSC);
    chk(reads == 8, "R8 poll count", reads, 8);
    chk(c == 4*WL + 3*WH + OEH + 8*(RD+GAP) + RSC + 1, "R8 done cycle", c, 4*WL + 3*WH + OEH + 8*(RD+GAP) + RSC + 1);
    chk(f_rst_n == 1'b1 && req_ready == 1'b1, "R8 back idle", {f_rst_n, req_ready}, 2'b11);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_prog_hi();
    t_prog_lo();
    t_sector();
    t_chip();
    t_busy_ignore();
    t_timeout();
    summary();
  end

endmodule